// File: doc/BRIEF.md
# Timer Compare Output Waveform Unit

This block is one compare channel of a general-purpose timer. On every count tick it compares the timer's running count with the channel's compare value. It also looks at a strobe from the timer that marks a period match. From these two events and a 3-bit output mode, it drives a single waveform pin.

The eight modes cover direct software control of the pin, latching set or reset, plain toggle, and four paired behaviours. In each paired mode the channel match performs one action and the period match performs the opposite one. The block also keeps a compare flag and raises an interrupt request when that flag is set and enabled. The count itself is generated elsewhere, and capture is not part of this channel.

Internally the pin is a two-state machine, `PIN_LOW` ⇄ `PIN_HIGH`. It moves on one of four named actions: HOLD, SET, CLR and TOG. In direct mode the action is ignored and the machine loads the software bit instead.

The flag is a second two-state machine, `FLG_IDLE` → `FLG_PEND`. It takes the transition *hit* on a ticked compare match. It returns from `FLG_PEND` to `FLG_IDLE` through the transition *clear* on a clear request, but only when no hit arrives in the same cycle.

Top module: `cmpout_unit`

## Requirements
- R1: After reset, pin_o, flag_o and irq_o are all 0.
- R2: With out_mode_i = 3'b000, pin_o takes the value of sw_out_i at the next clock edge, whether or not tick_i is high.
- R3: With out_mode_i = 3'b001, a channel match (tick_i high and count_i equal to cmp_val_i) sets pin_o. With out_mode_i = 3'b101, a channel match clears it. In both modes a period match does not change the pin.
- R4: With out_mode_i = 3'b010, a channel match toggles pin_o and a period match clears it. With out_mode_i = 3'b110, a channel match toggles pin_o and a period match sets it.
- R5: With out_mode_i = 3'b011, a channel match sets pin_o and a period match clears it. With out_mode_i = 3'b111, a channel match clears pin_o and a period match sets it.
- R6: With out_mode_i = 3'b100, a channel match toggles pin_o and a period match does not change it.
- R7: A match with tick_i low is not an event: in modes 3'b001 to 3'b111, pin_o and flag_o keep their value.
- R8: When a channel match and a period match arrive on the same tick, the channel-match action alone is applied.
- R9: flag_o becomes 1 at the clock edge that samples a channel match, in any mode. It stays 1 until flag_clr_i is sampled high. A match in the same cycle as a clear leaves it at 1.
- R10: irq_o is 1 exactly when flag_o is 1 and irq_en_i is 1.
- R11: pin_o is registered and changes at the clock edge that samples the tick carrying the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count-tick strobe qualifying both match events |
| count_i | input | CNT_W | Current timer count |
| cmp_val_i | input | CNT_W | Channel compare value |
| period_hit_i | input | 1 | Period-match strobe from the timer |
| out_mode_i | input | 3 | Output mode, encodings per R2 to R6 |
| sw_out_i | input | 1 | Software pin level used in mode 3'b000 |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Clears the compare flag |
| pin_o | output | 1 | Waveform pin |
| flag_o | output | 1 | Compare flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Both state machines hold a single bit, so a wrong action decode or a wrong pin state shows at pin_o one clock after the tick that carries the match. The bench therefore checks every step of its sequence against a reference model. The model carries the pin level forward, so a wrong toggle history also shows up on later steps.

A flag stuck in the wrong state shows on flag_o and irq_o on the very next cycle. Priority between simultaneous events is checked in three paired modes, each with opposite actions on the two events, so taking the wrong winner changes the pin level.

// File: rtl/cmpout_pkg.sv
package cmpout_pkg;

    typedef enum logic [2:0] {
        OM_DIRECT  = 3'b000,
        OM_SET     = 3'b001,
        OM_TOG_CLR = 3'b010,
        OM_SET_CLR = 3'b011,
        OM_TOGGLE  = 3'b100,
        OM_CLEAR   = 3'b101,
        OM_TOG_SET = 3'b110,
        OM_CLR_SET = 3'b111
    } out_mode_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TOG  = 2'd3
    } pin_act_e;

    typedef enum logic {
        PIN_LOW  = 1'b0,
        PIN_HIGH = 1'b1
    } pin_state_e;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flag_state_e;

endpackage

// File: rtl/cmpout_match.sv
module cmpout_match #(
    parameter int CNT_W = 16
) (
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             period_hit_i,
    output logic             ch_evt_o,
    output logic             per_evt_o
);
    // Both events exist only on a count tick.
    always_comb begin
        ch_evt_o  = tick_i && (count_i == cmp_val_i);
        per_evt_o = tick_i && period_hit_i;
    end
endmodule

// File: rtl/cmpout_action.sv
module cmpout_action
    import cmpout_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       ch_evt_i,
    input  logic       per_evt_i,
    output pin_act_e   act_o,
    output logic       direct_o
);
    pin_act_e ch_act;
    pin_act_e per_act;

    // Per-mode action for each of the two events.
    always_comb begin
        direct_o = 1'b0;
        ch_act   = ACT_HOLD;
        per_act  = ACT_HOLD;
        unique case (out_mode_e'(mode_i))
            OM_DIRECT:  direct_o = 1'b1;
            OM_SET:     ch_act = ACT_SET;
            OM_TOG_CLR: begin ch_act = ACT_TOG; per_act = ACT_CLR; end
            OM_SET_CLR: begin ch_act = ACT_SET; per_act = ACT_CLR; end
            OM_TOGGLE:  ch_act = ACT_TOG;
            OM_CLEAR:   ch_act = ACT_CLR;
            OM_TOG_SET: begin ch_act = ACT_TOG; per_act = ACT_SET; end
            OM_CLR_SET: begin ch_act = ACT_CLR; per_act = ACT_SET; end
            default:    direct_o = 1'b0;
        endcase
    end

    // Channel match outranks period match.
    always_comb begin
        if (ch_evt_i)       act_o = ch_act;
        else if (per_evt_i) act_o = per_act;
        else                act_o = ACT_HOLD;
    end
endmodule

// File: rtl/cmpout_pin_fsm.sv
module cmpout_pin_fsm
    import cmpout_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_act_e act_i,
    input  logic     direct_i,
    input  logic     sw_out_i,
    output logic     pin_o
);
    pin_state_e st_q;
    pin_state_e st_d;

    always_comb begin
        st_d = st_q;
        if (direct_i) begin
            st_d = sw_out_i ? PIN_HIGH : PIN_LOW;
        end else begin
            unique case (act_i)
                ACT_HOLD: st_d = st_q;
                ACT_SET:  st_d = PIN_HIGH;
                ACT_CLR:  st_d = PIN_LOW;
                ACT_TOG:  st_d = (st_q == PIN_HIGH) ? PIN_LOW : PIN_HIGH;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PIN_LOW;
        else        st_q <= st_d;
    end

    always_comb begin
        pin_o = (st_q == PIN_HIGH);
    end

    // SET must land high one edge later.
    p_set_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_i && act_i == ACT_SET) |=> pin_o);
    // TOG must invert the level.
    p_tog_inverts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_i && act_i == ACT_TOG) |=> (pin_o != $past(pin_o)));
endmodule

// File: rtl/cmpout_flag_fsm.sv
module cmpout_flag_fsm
    import cmpout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clr_i,
    output logic flag_o
);
    flag_state_e st_q;
    flag_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLG_IDLE: if (hit_i) st_d = FLG_PEND;
            FLG_PEND: if (clr_i && !hit_i) st_d = FLG_IDLE;
            default:  st_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        flag_o = (st_q == FLG_PEND);
    end

    p_flag_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/cmpout_unit.sv
module cmpout_unit
    import cmpout_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] cmp_val_i,
    input  logic             period_hit_i,
    input  logic [2:0]       out_mode_i,
    input  logic             sw_out_i,
    input  logic             irq_en_i,
    input  logic             flag_clr_i,
    output logic             pin_o,
    output logic             flag_o,
    output logic             irq_o
);
    logic     ch_evt;
    logic     per_evt;
    logic     direct;
    pin_act_e act;

    cmpout_match #(.CNT_W(CNT_W)) u_match (
        .tick_i       (tick_i),
        .count_i      (count_i),
        .cmp_val_i    (cmp_val_i),
        .period_hit_i (period_hit_i),
        .ch_evt_o     (ch_evt),
        .per_evt_o    (per_evt)
    );

    cmpout_action u_action (
        .mode_i    (out_mode_i),
        .ch_evt_i  (ch_evt),
        .per_evt_i (per_evt),
        .act_o     (act),
        .direct_o  (direct)
    );

    cmpout_pin_fsm u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_i    (act),
        .direct_i (direct),
        .sw_out_i (sw_out_i),
        .pin_o    (pin_o)
    );

    cmpout_flag_fsm u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (ch_evt),
        .clr_i  (flag_clr_i),
        .flag_o (flag_o)
    );

    always_comb begin
        irq_o = flag_o & irq_en_i;
    end

    p_direct_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode_i == 3'b000) |=> (pin_o == $past(sw_out_i)));
    p_latch_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode_i == 3'b001 && pin_o) |=> pin_o);
    p_latch_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode_i == 3'b101 && tick_i && count_i == cmp_val_i) |=> !pin_o);
    p_toggle_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode_i == 3'b100 && !(tick_i && count_i == cmp_val_i)) |=> $stable(pin_o));
    p_ch_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode_i == 3'b111 && tick_i && period_hit_i && count_i == cmp_val_i) |=> !pin_o);
    p_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && out_mode_i != 3'b000) |=> $stable(pin_o));
    p_flag_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && count_i == cmp_val_i) |=> flag_o);
endmodule

// File: tb/tb_cmpout_unit.sv
module tb_cmpout_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic [15:0] count_i = '0;
    logic [15:0] cmp_val_i = 16'd100;
    logic        period_hit_i = 1'b0;
    logic [2:0]  out_mode_i = 3'b000;
    logic        sw_out_i = 1'b0;
    logic        irq_en_i = 1'b0;
    logic        flag_clr_i = 1'b0;
    logic        pin_o, flag_o, irq_o;

    int n_run = 0;
    int n_fail = 0;
    logic m_pin = 1'b0;
    logic m_flag = 1'b0;
    bit   finished = 1'b0;

    typedef struct {
        logic  pin;
        logic  flag;
        logic  irq;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    cmpout_unit #(.CNT_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_i(count_i),
        .cmp_val_i(cmp_val_i), .period_hit_i(period_hit_i),
        .out_mode_i(out_mode_i), .sw_out_i(sw_out_i), .irq_en_i(irq_en_i),
        .flag_clr_i(flag_clr_i), .pin_o(pin_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic tk, input logic [15:0] cnt, input logic pe,
                        input logic [2:0] md, input logic sw, input logic ie,
                        input logic clr, input string tag);
        logic ch, pv;
        exp_t e;
        @(negedge clk);
        tick_i = tk; count_i = cnt; period_hit_i = pe; out_mode_i = md;
        sw_out_i = sw; irq_en_i = ie; flag_clr_i = clr;
        ch = tk && (cnt == cmp_val_i);
        pv = tk && pe;
        if (md == 3'b000) m_pin = sw;
        else if (ch) begin
            case (md)
                3'b001, 3'b011: m_pin = 1'b1;
                3'b101, 3'b111: m_pin = 1'b0;
                default:        m_pin = ~m_pin;
            endcase
        end else if (pv) begin
            case (md)
                3'b010, 3'b011: m_pin = 1'b0;
                3'b110, 3'b111: m_pin = 1'b1;
                default:        m_pin = m_pin;
            endcase
        end
        if (ch) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        e.pin = m_pin; e.flag = m_flag; e.irq = m_flag & ie; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare just after each edge.
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.tag, "pin", pin_o, e.pin);
            check(e.tag, "flag", flag_o, e.flag);
            check(e.tag, "irq", irq_o, e.irq);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        check("R1", "pin", pin_o, 1'b0);
        check("R1", "flag", flag_o, 1'b0);
        check("R1", "irq", irq_o, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        step(0, 16'd0,   0, 3'b000, 1, 0, 0, "R2");
        step(0, 16'd0,   0, 3'b000, 0, 0, 0, "R2");
        step(1, 16'd50,  0, 3'b001, 0, 0, 0, "R7");
        step(0, 16'd100, 0, 3'b001, 0, 0, 0, "R7");
        step(1, 16'd100, 0, 3'b001, 0, 0, 0, "R3");
        step(1, 16'd7,   1, 3'b001, 0, 0, 0, "R3");
        step(1, 16'd100, 0, 3'b101, 0, 0, 0, "R3");
        step(1, 16'd7,   1, 3'b101, 0, 0, 1, "R9");
        step(1, 16'd100, 0, 3'b100, 0, 0, 0, "R6");
        step(1, 16'd7,   1, 3'b100, 0, 0, 0, "R6");
        step(1, 16'd100, 0, 3'b100, 0, 0, 1, "R9");
        step(0, 16'd0,   0, 3'b100, 0, 0, 1, "R9");
        step(1, 16'd100, 0, 3'b010, 0, 0, 0, "R4");
        step(1, 16'd7,   1, 3'b010, 0, 0, 0, "R4");
        step(1, 16'd100, 0, 3'b110, 0, 0, 0, "R4");
        step(1, 16'd100, 0, 3'b110, 0, 0, 0, "R4");
        step(1, 16'd7,   1, 3'b110, 0, 0, 0, "R4");
        step(1, 16'd7,   1, 3'b011, 0, 0, 0, "R5");
        step(1, 16'd100, 0, 3'b011, 0, 0, 0, "R5");
        step(1, 16'd100, 0, 3'b111, 0, 0, 0, "R5");
        step(1, 16'd7,   1, 3'b111, 0, 0, 0, "R5");
        step(0, 16'd7,   1, 3'b011, 0, 0, 0, "R7");
        step(1, 16'd100, 1, 3'b111, 0, 0, 0, "R8");
        step(1, 16'd100, 1, 3'b010, 0, 0, 0, "R8");
        step(1, 16'd100, 1, 3'b110, 0, 0, 0, "R8");
        step(0, 16'd0,   0, 3'b110, 0, 1, 0, "R10");
        step(0, 16'd0,   0, 3'b110, 0, 0, 0, "R10");
        step(1, 16'd100, 0, 3'b001, 0, 1, 0, "R11");
        step(0, 16'd0,   0, 3'b001, 0, 1, 1, "R10");
        step(0, 16'd0,   0, 3'b000, 1, 1, 0, "R2");
        step(1, 16'd100, 0, 3'b000, 0, 1, 0, "R9");
        step(0, 16'd0,   0, 3'b000, 0, 0, 1, "R9");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule